// File: doc/BRIEF.md
# Bit-Test Instruction Sequencer

This block decodes and runs the two encodings of a 16-bit CISC processor's bit-test instruction. One encoding takes the bit number from a data register. The other takes it from an immediate extension word. The block does not change the destination operand. Its only architectural result is the zero flag: the flag is set when the chosen bit of the destination is clear.

A front end hands over one opcode word while the block is idle. The block then runs its own ordered cycle sequence. It pulls extension words and tail prefetches through a request/acknowledge prefetch port. It reads the data and address register files through select/value port pairs. It issues single byte reads on a request/acknowledge memory port. For the post-increment and pre-decrement modes it writes the adjusted address register back. Opcodes it does not support are rejected with a one-cycle illegal pulse and no bus activity.

Top module: `btst_unit`

## Requirements
- R1: An opcode with (op & 0xF1C0) == 0x0100 is the register form. The bit number is the data register selected by opcode bits 11:9.
- R2: An opcode with (op & 0xFFC0) == 0x0800 is the immediate form. The bit number is the first extension word fetched, and that word is consumed before any displacement or address word.
- R3: Opcode bits 5:3 give the destination mode and bits 2:0 give the register. The supported modes are 0 (Dn), 2 ((An)), 3 ((An)+), 4 (-(An)), 5 ((d16,An)), 7/0 (abs.w) and 7/1 (abs.l). Any other mode, and any opcode matching neither form, produces a one-cycle `illegal` pulse with no `done`, no prefetch and no memory read.
- R4: With a data-register destination the test is 32-bit, and the bit index is the bit number modulo 32.
- R5: With a memory destination the test is on one byte, and the bit index is the bit number modulo 8. The byte address is An for modes 2, 3 and 4 (An after the decrement for mode 4). It is An plus the sign-extended displacement for mode 5, the sign-extended word for abs.w, and the high word followed by the low word for abs.l.
- R6: `zero_flag` is 1 when the selected bit is 0 and 0 when it is 1.
- R7: In mode 3 the address register is written with An+1 in the cycle the byte read is acknowledged. In mode 4 an internal cycle that writes An-1 comes before the read. No other mode writes a register.
- R8: With a data-register destination, the register form runs one prefetch and then one internal cycle. The immediate form runs two prefetches and then one internal cycle.
- R9: With a memory destination the order is: extension-word prefetches (one for mode 5 and abs.w, two for abs.l, plus the immediate word), the optional decrement cycle, the byte read, one tail prefetch, and then `done`.
- R10: `done` is a one-cycle pulse that comes with a valid `zero_flag`. `op_ready` is high only when idle, and while it is high no bus request and no register write is active.
- R11: A prefetch or memory request stays asserted until it is acknowledged. The memory address stays stable while the read waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode offered |
| op_word | input | 16 | Opcode word |
| op_ready | output | 1 | Idle; opcode accepted when op_valid is high |
| pf_req | output | 1 | Prefetch cycle request |
| pf_ack | input | 1 | Prefetch cycle acknowledge |
| pf_data | input | 16 | Prefetched word, valid with pf_ack |
| dsrc_sel | output | 3 | Data register select for the bit number |
| dsrc_val | input | 32 | Selected bit-number register value |
| ddst_sel | output | 3 | Data register select for the destination |
| ddst_val | input | 32 | Selected destination register value |
| areg_sel | output | 3 | Address register select |
| areg_val | input | 32 | Selected address register value |
| areg_we | output | 1 | Address register write strobe |
| areg_wdata | output | 32 | Address register write value |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_ack | input | 1 | Byte read acknowledge |
| mem_rdata | input | 8 | Byte read data, valid with mem_ack |
| done | output | 1 | Instruction finished; zero_flag valid |
| zero_flag | output | 1 | New zero flag |
| illegal | output | 1 | Unsupported opcode pulse |

## Verification
Every supported mode is run in both encodings, with bit numbers above 31 and above 7. Only a correct modulo (32 for registers, 8 for bytes) then picks the right bit, and each value is run once with the bit set and once with it clear, so an inverted flag cannot pass. The same opcodes are run again with stalled prefetch and memory acknowledges. This separates a sequencer that waits for each handshake from one that advances on a fixed count. Comparing the cycle kinds one by one catches a missing or extra prefetch or idle cycle in each mode. Negative displacement and abs.w words show sign extension, abs.l checks word order, and several illegal destination modes plus one foreign opcode confirm the rejection path.

// File: rtl/btst_pkg.sv
package btst_pkg;
    localparam int OP_W      = 16;
    localparam int RSEL_W    = 3;
    localparam int EXT_SLOTS = 4;
    localparam int EXT_CNT_W = $clog2(EXT_SLOTS);

    localparam logic [OP_W-1:0] REGFORM_MASK  = 16'hF1C0;
    localparam logic [OP_W-1:0] REGFORM_MATCH = 16'h0100;
    localparam logic [OP_W-1:0] IMMFORM_MASK  = 16'hFFC0;
    localparam logic [OP_W-1:0] IMMFORM_MATCH = 16'h0800;

    typedef enum logic [2:0] {
        AM_DREG, AM_IND, AM_POST, AM_PRE, AM_DISP, AM_ABSW, AM_ABSL, AM_NONE
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EXT, ST_DEC, ST_READ, ST_PF, ST_INT, ST_DONE, ST_ILL
    } st_e;

    typedef struct packed {
        logic                 legal;
        logic                 imm_form;
        amode_e               mode;
        logic [EXT_CNT_W-1:0] n_ext;
        logic [EXT_CNT_W-1:0] base;
    } dec_t;

    function automatic amode_e classify(input logic [5:0] ea);
        case (ea[5:3])
            3'd0:    return AM_DREG;
            3'd2:    return AM_IND;
            3'd3:    return AM_POST;
            3'd4:    return AM_PRE;
            3'd5:    return AM_DISP;
            3'd7:    return (ea[2:0] == 3'd0) ? AM_ABSW :
                            (ea[2:0] == 3'd1) ? AM_ABSL : AM_NONE;
            default: return AM_NONE;
        endcase
    endfunction

    function automatic logic [EXT_CNT_W-1:0] mode_words(input amode_e m);
        case (m)
            AM_DISP, AM_ABSW: return EXT_CNT_W'(1);
            AM_ABSL:          return EXT_CNT_W'(2);
            default:          return '0;
        endcase
    endfunction

    function automatic st_e after_ext(input amode_e m);
        case (m)
            AM_DREG: return ST_PF;
            AM_PRE:  return ST_DEC;
            default: return ST_READ;
        endcase
    endfunction
endpackage

// File: rtl/btst_decode.sv
module btst_decode
    import btst_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output dec_t            dec
);
    logic   reg_hit, imm_hit;
    amode_e m;

    always_comb begin
        reg_hit      = (op & REGFORM_MASK) == REGFORM_MATCH;
        imm_hit      = (op & IMMFORM_MASK) == IMMFORM_MATCH;
        m            = classify(op[5:0]);
        dec.legal    = (reg_hit || imm_hit) && (m != AM_NONE);
        dec.imm_form = imm_hit;
        dec.mode     = m;
        dec.base     = EXT_CNT_W'(imm_hit);
        dec.n_ext    = mode_words(m) + EXT_CNT_W'(imm_hit);
    end
endmodule

// File: rtl/btst_ea.sv
module btst_ea
    import btst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  amode_e            mode,
    input  logic [ADDR_W-1:0] base_reg,
    input  logic [OP_W-1:0]   w_hi,
    input  logic [OP_W-1:0]   w_lo,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] hi_sext;

    always_comb begin
        hi_sext = {{(ADDR_W-OP_W){w_hi[OP_W-1]}}, w_hi};
        case (mode)
            AM_DISP: addr = base_reg + hi_sext;
            AM_ABSW: addr = hi_sext;
            AM_ABSL: addr = ADDR_W'({w_hi, w_lo});
            default: addr = base_reg;
        endcase
    end
endmodule

// File: rtl/btst_bitsel.sv
module btst_bitsel #(
    parameter int REG_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic              wide,
    input  logic [REG_W-1:0]  bit_num,
    input  logic [REG_W-1:0]  dval,
    input  logic [BYTE_W-1:0] bval,
    output logic              zero
);
    always_comb begin
        if (wide)
            zero = ((dval >> (bit_num % REG_W)) & REG_W'(1)) == '0;
        else
            zero = ((bval >> (bit_num % BYTE_W)) & BYTE_W'(1)) == '0;
    end
endmodule

// File: rtl/btst_unit.sv
module btst_unit
    import btst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_word,
    output logic              op_ready,
    output logic              pf_req,
    input  logic              pf_ack,
    input  logic [OP_W-1:0]   pf_data,
    output logic [RSEL_W-1:0] dsrc_sel,
    input  logic [REG_W-1:0]  dsrc_val,
    output logic [RSEL_W-1:0] ddst_sel,
    input  logic [REG_W-1:0]  ddst_val,
    output logic [RSEL_W-1:0] areg_sel,
    input  logic [ADDR_W-1:0] areg_val,
    output logic              areg_we,
    output logic [ADDR_W-1:0] areg_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              done,
    output logic              zero_flag,
    output logic              illegal
);
    st_e                  st;
    dec_t                 dec;
    logic                 imm_q;
    amode_e               mode_q;
    logic [EXT_CNT_W-1:0] n_ext_q, base_q, ext_cnt;
    logic [OP_W-1:0]      ext_w [EXT_SLOTS];
    logic [RSEL_W-1:0]    src_reg_q, dst_reg_q;
    logic [BYTE_W-1:0]    byte_q;
    logic                 zero_q, z_calc;
    logic [REG_W-1:0]     bit_num;

    btst_decode u_dec (.op(op_word), .dec(dec));

    btst_ea #(.ADDR_W(ADDR_W)) u_ea (
        .mode(mode_q), .base_reg(areg_val),
        .w_hi(ext_w[base_q]), .w_lo(ext_w[base_q + EXT_CNT_W'(1)]),
        .addr(mem_addr)
    );

    assign bit_num = imm_q ? REG_W'(ext_w[0]) : dsrc_val;

    btst_bitsel #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_bit (
        .wide(mode_q == AM_DREG), .bit_num(bit_num),
        .dval(ddst_val), .bval(byte_q), .zero(z_calc)
    );

    always_comb begin
        op_ready   = (st == ST_IDLE);
        pf_req     = (st == ST_EXT) || (st == ST_PF);
        mem_req    = (st == ST_READ);
        done       = (st == ST_DONE);
        illegal    = (st == ST_ILL);
        zero_flag  = zero_q;
        dsrc_sel   = src_reg_q;
        ddst_sel   = dst_reg_q;
        areg_sel   = dst_reg_q;
        areg_we    = (st == ST_DEC) || (mem_req && mem_ack && mode_q == AM_POST);
        areg_wdata = (st == ST_DEC) ? areg_val - ADDR_W'(1) : areg_val + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            imm_q     <= 1'b0;
            mode_q    <= AM_DREG;
            n_ext_q   <= '0;
            base_q    <= '0;
            ext_cnt   <= '0;
            src_reg_q <= '0;
            dst_reg_q <= '0;
            byte_q    <= '0;
            zero_q    <= 1'b0;
            for (int i = 0; i < EXT_SLOTS; i++) ext_w[i] <= '0;
        end else begin
            case (st)
                ST_IDLE: if (op_valid) begin
                    imm_q     <= dec.imm_form;
                    mode_q    <= dec.mode;
                    n_ext_q   <= dec.n_ext;
                    base_q    <= dec.base;
                    ext_cnt   <= '0;
                    src_reg_q <= op_word[11:9];
                    dst_reg_q <= op_word[2:0];
                    if (!dec.legal)          st <= ST_ILL;
                    else if (dec.n_ext != 0) st <= ST_EXT;
                    else                     st <= after_ext(dec.mode);
                end
                ST_EXT: if (pf_ack) begin
                    ext_w[ext_cnt] <= pf_data;
                    ext_cnt        <= ext_cnt + EXT_CNT_W'(1);
                    if (ext_cnt + EXT_CNT_W'(1) == n_ext_q) st <= after_ext(mode_q);
                end
                ST_DEC:  st <= ST_READ;
                ST_READ: if (mem_ack) begin
                    byte_q <= mem_rdata;
                    st     <= ST_PF;
                end
                ST_PF: if (pf_ack) begin
                    if (mode_q == AM_DREG) st <= ST_INT;
                    else begin
                        zero_q <= z_calc;
                        st     <= ST_DONE;
                    end
                end
                ST_INT: begin
                    zero_q <= z_calc;
                    st     <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R11
    pf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pf_req && !pf_ack |=> pf_req);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && op_ready);
    // R10
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        op_ready |-> !pf_req && !mem_req && !areg_we);
    // R3
    ill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !done && !pf_req && !mem_req && !areg_we);
    // R7
    areg_once_chk: assert property (@(posedge clk) disable iff (rst)
        areg_we |=> !areg_we);
endmodule

// File: tb/tb_btst_unit.sv
module tb_btst_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [15:0] op_word;
    logic        op_ready, pf_req, pf_ack, areg_we, mem_req, mem_ack;
    logic [15:0] pf_data;
    logic [2:0]  dsrc_sel, ddst_sel, areg_sel;
    logic [31:0] dsrc_val, ddst_val, areg_val, areg_wdata, mem_addr;
    logic [7:0]  mem_rdata;
    logic        done, zero_flag, illegal;

    logic [31:0] dregs [8];
    logic [31:0] aregs [8];
    logic [15:0] pfq [8];
    logic [2:0]  pf_ptr;

    int checks = 0;
    int errors = 0;

    byte         ek  [16];
    logic        ewe [16];
    logic [31:0] ewv [16];
    logic [31:0] ead [16];
    logic        ez  [16];
    int          en;

    always #10 clk = ~clk;

    assign dsrc_val = dregs[dsrc_sel];
    assign ddst_val = dregs[ddst_sel];
    assign areg_val = aregs[areg_sel];
    assign pf_data  = pfq[pf_ptr];

    btst_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word), .op_ready(op_ready),
        .pf_req(pf_req), .pf_ack(pf_ack), .pf_data(pf_data),
        .dsrc_sel(dsrc_sel), .dsrc_val(dsrc_val), .ddst_sel(ddst_sel), .ddst_val(ddst_val),
        .areg_sel(areg_sel), .areg_val(areg_val), .areg_we(areg_we), .areg_wdata(areg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .zero_flag(zero_flag), .illegal(illegal)
    );

    function automatic logic [7:0] memb(input logic [31:0] a);
        return a[7:0] ^ a[23:16] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input byte k, input logic we, input logic [31:0] wv,
                        input logic [31:0] a, input logic z);
        ek[en] = k; ewe[en] = we; ewv[en] = wv; ead[en] = a; ez[en] = z;
        en++;
    endtask

    // Reference model: expected cycle list from the requirements
    task automatic build(input logic [15:0] op, input logic [15:0] w0,
                         input logic [15:0] w1, input logic [15:0] w2);
        logic        regf, immf, ok, z;
        logic [2:0]  m, r;
        logic [31:0] src, a, hi_s;
        logic [15:0] ws [3];
        logic [15:0] hi, lo;
        int          mw, base;
        en   = 0;
        regf = (op & 16'hF1C0) == 16'h0100;
        immf = (op & 16'hFFC0) == 16'h0800;
        m = op[5:3]; r = op[2:0];
        ok = (regf || immf) &&
             (m == 0 || m == 2 || m == 3 || m == 4 || m == 5 || (m == 7 && r <= 1));
        src  = immf ? {16'h0, w0} : dregs[op[11:9]];
        mw   = (m == 5 || (m == 7 && r == 0)) ? 1 : (m == 7 && r == 1) ? 2 : 0;
        base = immf ? 1 : 0;
        ws[0] = w0; ws[1] = w1; ws[2] = w2;
        hi = ws[base]; lo = ws[base + 1];
        hi_s = {{16{hi[15]}}, hi};
        if (!ok) push("I", 0, 0, 0, 0);
        else if (m == 0) begin
            if (immf) push("P", 0, 0, 0, 0);
            push("P", 0, 0, 0, 0);
            push("N", 0, 0, 0, 0);
            z = dregs[r][src % 32] == 1'b0;
            push("D", 0, 0, 0, z);
        end else begin
            for (int i = 0; i < base + mw; i++) push("P", 0, 0, 0, 0);
            a = aregs[r];
            if (m == 4) begin
                a = a - 1;
                push("N", 1, a, 0, 0);
            end
            if (m == 5) a = aregs[r] + hi_s;
            else if (m == 7 && r == 0) a = hi_s;
            else if (m == 7) a = {hi, lo};
            push("R", m == 3, aregs[r] + 1, a, 0);
            push("P", 0, 0, 0, 0);
            z = memb(a) >> (src % 8) & 8'h1 ? 1'b0 : 1'b1;
            push("D", 0, 0, 0, z);
        end
    endtask

    task automatic run_op(input logic [15:0] op, input logic [15:0] w0,
                          input logic [15:0] w1, input logic [15:0] w2,
                          input int pfd, input int md, input string tag);
        int ptr, cyc, pf_wait, mem_wait;
        bit pend_pf, pend_we, bad;
        logic [2:0]  pend_reg;
        logic [31:0] pend_val;
        byte kind;
        logic exp_we;
        pfq[0] = w0; pfq[1] = w1; pfq[2] = w2;
        for (int i = 3; i < 8; i++) pfq[i] = 16'h4E71;
        pf_ptr = 0;
        build(op, w0, w1, w2);
        @(negedge clk);
        chk(op_ready, tag, "op_ready before issue (R10)", op_ready, 1);
        op_valid = 1'b1; op_word = op;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        ptr = 0; cyc = 0; pf_wait = 0; mem_wait = 0;
        pend_pf = 0; pend_we = 0; bad = 0;
        while (ptr < en && cyc < 100 && !bad) begin
            if (pend_pf) pf_ptr = pf_ptr + 1;
            if (pend_we) aregs[pend_reg] = pend_val;
            pend_pf = 0; pend_we = 0;
            #1;
            pf_ack    = pf_req && (pf_wait >= pfd);
            mem_ack   = mem_req && (mem_wait >= md);
            mem_rdata = memb(mem_addr);
            #1;
            kind = illegal ? "I" : done ? "D" : pf_req ? "P" : mem_req ? "R" : "N";
            chk(kind == ek[ptr], tag, "cycle kind", 32'(kind), 32'(ek[ptr]));
            if (kind != ek[ptr]) bad = 1;
            else begin
                exp_we = ewe[ptr] && (kind != "R" || mem_ack);
                chk(areg_we == exp_we, tag, "areg write strobe (R7)", 32'(areg_we), 32'(exp_we));
                if (areg_we && exp_we)
                    chk(areg_wdata == ewv[ptr], tag, "areg write value (R7)", areg_wdata, ewv[ptr]);
                pend_we = areg_we; pend_reg = areg_sel; pend_val = areg_wdata;
                if (kind == "R")
                    chk(mem_addr == ead[ptr], tag, "byte address (R5)", mem_addr, ead[ptr]);
                if (kind == "D")
                    chk(zero_flag == ez[ptr], tag, "zero flag (R6)", 32'(zero_flag), 32'(ez[ptr]));
                if (kind == "P") begin
                    if (pf_ack) begin ptr++; pend_pf = 1; pf_wait = 0; end
                    else pf_wait++;
                end else if (kind == "R") begin
                    if (mem_ack) begin ptr++; mem_wait = 0; end
                    else mem_wait++;
                end else ptr++;
            end
            @(negedge clk);
            cyc++;
        end
        pf_ack = 1'b0; mem_ack = 1'b0;
        if (pend_we) aregs[pend_reg] = pend_val;
        chk(cyc < 100, tag, "sequence length", cyc, 100);
        #1;
        chk(op_ready && !done && !illegal, tag, "idle after end (R10)", 32'(op_ready), 1);
        for (int i = 0; i < 60 && !op_ready; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_word = 16'h0;
        pf_ack = 1'b0; mem_ack = 1'b0; mem_rdata = 8'h0; pf_ptr = 0;
        for (int i = 0; i < 8; i++) pfq[i] = 16'h0;
        dregs[0] = 32'h0000_0000; dregs[1] = 32'h0000_0020; dregs[2] = 32'h8000_0001;
        dregs[3] = 32'd37;        dregs[4] = 32'd38;        dregs[5] = 32'd15;
        dregs[6] = 32'hFFFF_FFFE; dregs[7] = 32'd63;
        aregs[0] = 32'h0000_1000; aregs[1] = 32'h0000_2000; aregs[2] = 32'h0001_0010;
        aregs[3] = 32'h0002_0021; aregs[4] = 32'h0003_0040; aregs[5] = 32'h0004_0100;
        aregs[6] = 32'h0005_0000; aregs[7] = 32'h0006_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(op_ready && !done && !illegal && !pf_req && !mem_req && !areg_we,
            "R10", "reset state", {op_ready, done, illegal, pf_req, mem_req, areg_we}, 32'h20);

        for (int pass = 0; pass < 2; pass++) begin
            // R1 R4 R8: D3=37 -> bit 5 of D1 (set) ; D4=38 -> bit 6 (clear)
            run_op(16'h0701, 0, 0, 0, pass, pass, "R1 R4 R8 reg Dn bit set");
            run_op(16'h0901, 0, 0, 0, pass, pass, "R1 R4 R6 reg Dn bit clear");
            run_op(16'h0E02, 0, 0, 0, pass, pass, "R1 R4 R6 reg Dn index 63");
            // R2 R4 R8: immediate 33 -> bit 1 of D6
            run_op(16'h0806, 16'h0021, 0, 0, pass, pass, "R2 R4 R8 imm Dn");
            run_op(16'h0802, 16'h0040, 0, 0, pass, pass, "R2 R4 R6 imm Dn index 64");
            // R5 R9: (A2), (A3)+, -(A4)
            run_op(16'h0312, 0, 0, 0, pass, pass + 1, "R1 R5 R9 reg (An)");
            run_op(16'h011B, 0, 0, 0, pass, pass, "R5 R7 R9 reg (An)+");
            run_op(16'h0824, 16'h000B, 0, 0, pass + 1, pass, "R2 R5 R7 R9 imm -(An)");
            run_op(16'h0B24, 0, 0, 0, pass, pass, "R5 R7 R9 reg -(An)");
            // displacement, abs.w, abs.l
            run_op(16'h052D, 16'hFFF0, 0, 0, pass, pass, "R5 R9 reg (d16,An) negative");
            run_op(16'h082D, 16'h0102, 16'h0123, 0, pass, pass, "R2 R5 R9 imm (d16,An)");
            run_op(16'h0838, 16'h0003, 16'h8000, 0, pass, pass, "R2 R5 R9 imm abs.w sign");
            run_op(16'h0B39, 16'h0012, 16'h3456, 0, pass, pass + 2, "R5 R9 R11 reg abs.l");
            run_op(16'h0839, 16'h0007, 16'h00AB, 16'hCDEF, pass + 2, pass, "R2 R9 R11 imm abs.l");
            // R3: illegal destinations and a foreign opcode
            run_op(16'h0109, 0, 0, 0, pass, pass, "R3 An destination");
            run_op(16'h083C, 0, 0, 0, pass, pass, "R3 immediate destination");
            run_op(16'h0130, 0, 0, 0, pass, pass, "R3 indexed destination");
            run_op(16'h083A, 0, 0, 0, pass, pass, "R3 pc-relative destination");
            run_op(16'h4E71, 0, 0, 0, pass, pass, "R3 foreign opcode");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule